// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches for a stalled processor. A down-counter runs on the system clock while the watchdog is enabled. When the counter reaches zero it restarts from a programmed load value. The first timeout latches an interrupt, which gives software a chance to record its state. If the counter reaches zero again before software clears that interrupt, the block emits a one-cycle system reset pulse. Because of this, a reset needs two timeouts in a row without service.

Software reaches the block over a plain register bus: a word address, write data, a write strobe and combinational read data. Writes to the registers are refused until a magic key has been written to the lock register. A debug-halt input can freeze the counter, but only if a test bit permits it.

Register word addresses are:
- 0: load value
- 1: current count, read-only
- 2: control (bit 0 enables counting and the interrupt, bit 1 enables the reset)
- 3: raw status in bit 0, read-only
- 4: clear (writing bit 0 as 1 clears the raw status)
- 5: lock
- 6: test (bit 8 allows the debug-halt input to stall the counter)

Top module: `twostage_wdt`

## Requirements
- R1: After reset the block reads as follows: unlocked (lock register reads 0), load and count at 0xFFFFFFFF, control 0, raw status 0, test 0. Both irqOut and sysRstOut are low.
- R2: Writing 0x1ACCE551 to address 5 unlocks the block. Writing any other value to address 5 locks it. Address 5 reads 1 while locked and 0 while unlocked. Writes to address 5 are accepted in both states.
- R3: While locked, writes to any address other than 5 leave every register unchanged.
- R4: While control bit 0 is set, the count drops by one on each clock. Address 1 returns the current count.
- R5: When the count is zero on an enabled clock, the count reloads from the load value and raw status bit 0 sets. irqOut equals raw status AND control bit 0.
- R6: A second expiry while raw status is still set, with control bit 1 set, drives sysRstOut high for exactly one cycle. On the next clock every register returns to its R1 value.
- R7: Writing 1 in bit 0 of address 4 clears raw status. The next expiry is then treated as a first timeout. A clear in the same cycle as an expiry also makes that expiry a first timeout.
- R8: A write to address 0 sets the load value and the count on the same clock. It takes precedence over an expiry in that cycle, so that expiry is not counted.
- R9: Once control bit 0 is set, writes cannot clear it. Only a reset clears it.
- R10: With test bit 8 set, the count holds while dbgHalt is high. With test bit 8 clear, dbgHalt has no effect.
- R11: With control bit 1 clear, repeated expiries never raise sysRstOut, and raw status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Write data |
| regWe | input | 1 | Write strobe, one register write per cycle |
| regRdata | output | 32 | Read data for regAddr |
| dbgHalt | input | 1 | Debug-halt request |
| irqOut | output | 1 | Timeout interrupt |
| sysRstOut | output | 1 | One-cycle system reset request |

## Verification
Most internal faults show up at the ports within one timeout period.
- A wrong count or reload appears at once on the count read-back and moves the interrupt edge by the same number of cycles.
- A raw status bit that sticks or is lost makes the reset pulse appear one period early, one period late, or never.
- A lock flag with the wrong sense shows either in the lock read-back or in a write that lands when it should be refused, and the read on the next cycle exposes it.

The reference model tracks each of these states every clock, so the first wrong cycle is reported.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD  = 4'd0,
    REG_VALUE = 4'd1,
    REG_CTRL  = 4'd2,
    REG_RAW   = 4'd3,
    REG_CLEAR = 4'd4,
    REG_LOCK  = 4'd5,
    REG_TEST  = 4'd6
  } regSel_e;

  // strobes from the control side to the counting datapath
  typedef struct packed {
    logic loadWr;
    logic clrRaw;
    logic run;
    logic rstEn;
  } dpStrobe_t;

endpackage

// File: rtl/twostage_wdt_ctrl.sv
module twostage_wdt_ctrl
  import twostage_wdt_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY       = 32'h1ACC_E551,
  parameter int                STALL_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  logic              dbgHalt,
  input  logic              softRst,
  input  logic [DATA_W-1:0] curCount,
  input  logic [DATA_W-1:0] curLoad,
  input  logic              rawStat,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  logic locked;
  logic intEn;
  logic rstEn;
  logic stallEn;
  logic wrOpen;

  assign wrOpen = regWe && !locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked  <= 1'b0;
      intEn   <= 1'b0;
      rstEn   <= 1'b0;
      stallEn <= 1'b0;
    end else if (softRst) begin
      locked  <= 1'b0;
      intEn   <= 1'b0;
      rstEn   <= 1'b0;
      stallEn <= 1'b0;
    end else begin
      if (regWe && regAddr == REG_LOCK) begin
        locked <= (regWdata != KEY);
      end
      if (wrOpen && regAddr == REG_CTRL) begin
        intEn <= intEn | regWdata[0];
        rstEn <= regWdata[1];
      end
      if (wrOpen && regAddr == REG_TEST) begin
        stallEn <= regWdata[STALL_BIT];
      end
    end
  end

  always_comb begin
    strobe.loadWr = wrOpen && (regAddr == REG_LOAD);
    strobe.clrRaw = wrOpen && (regAddr == REG_CLEAR) && regWdata[0];
    strobe.run    = intEn && !(stallEn && dbgHalt);
    strobe.rstEn  = rstEn;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_LOAD:  regRdata = curLoad;
      REG_VALUE: regRdata = curCount;
      REG_CTRL:  regRdata[1:0] = {rstEn, intEn};
      REG_RAW:   regRdata[0] = rawStat;
      REG_LOCK:  regRdata[0] = locked;
      REG_TEST:  regRdata[STALL_BIT] = stallEn;
      default:   regRdata = '0;
    endcase
  end

  assign irqOut = rawStat & intEn;

  // R9
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    intEn && !softRst |=> intEn);

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked && regWe && regAddr != REG_LOCK && !softRst |=> $stable({intEn, rstEn, stallEn}));

  // R2
  lock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == REG_LOCK && regWdata == KEY && !softRst |=> !locked);

endmodule

// File: rtl/twostage_wdt_datapath.sv
module twostage_wdt_datapath
  import twostage_wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] curCount,
  output logic [DATA_W-1:0] curLoad,
  output logic              rawStat,
  output logic              rstPulse
);

  localparam logic [DATA_W-1:0] INIT_VAL = '1;

  logic expire;

  assign expire = strobe.run && (curCount == '0) && !strobe.loadWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLoad  <= INIT_VAL;
      curCount <= INIT_VAL;
      rawStat  <= 1'b0;
      rstPulse <= 1'b0;
    end else if (rstPulse) begin
      curLoad  <= INIT_VAL;
      curCount <= INIT_VAL;
      rawStat  <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= expire && rawStat && !strobe.clrRaw && strobe.rstEn;
      rawStat  <= (rawStat && !strobe.clrRaw) || expire;
      if (strobe.loadWr) begin
        curLoad  <= regWdata;
        curCount <= regWdata;
      end else if (expire) begin
        curCount <= curLoad;
      end else if (strobe.run) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);

  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> $past(rawStat) && $past(strobe.rstEn));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run && !strobe.loadWr && !rstPulse |=> curCount == $past(curCount));

  // R8
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWr && !rstPulse |=> curCount == $past(regWdata));

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY       = 32'h1ACC_E551,
  parameter int                STALL_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  input  logic              dbgHalt,
  output logic              irqOut,
  output logic              sysRstOut
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] curCount;
  logic [DATA_W-1:0] curLoad;
  logic              rawStat;

  twostage_wdt_ctrl #(
    .DATA_W(DATA_W), .KEY(KEY), .STALL_BIT(STALL_BIT)
  ) ctrlUnit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .dbgHalt(dbgHalt), .softRst(sysRstOut),
    .curCount(curCount), .curLoad(curLoad), .rawStat(rawStat),
    .strobe(strobe), .regRdata(regRdata), .irqOut(irqOut)
  );

  twostage_wdt_datapath #(
    .DATA_W(DATA_W)
  ) dpUnit (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .curCount(curCount), .curLoad(curLoad), .rawStat(rawStat),
    .rstPulse(sysRstOut)
  );

endmodule

// File: tb/twostage_wdt_test.sv
`timescale 1ns/100ps
module twostage_wdt_test;

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWdata = 32'd0;
  logic        regWe = 1'b0;
  logic        dbgHalt = 1'b0;
  logic [31:0] regRdata;
  logic        irqOut;
  logic        sysRstOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit sawPulse = 0;

  always #2.5 clk = ~clk;

  twostage_wdt uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .dbgHalt(dbgHalt),
    .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  // behavioural reference model
  logic [31:0] mLoad, mCnt;
  bit mRaw, mPulse, mLocked, mIntEn, mRstEn, mStall;

  task automatic modelClear();
    mLoad = 32'hFFFF_FFFF; mCnt = 32'hFFFF_FFFF;
    mRaw = 0; mPulse = 0; mLocked = 0; mIntEn = 0; mRstEn = 0; mStall = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelClear();
    else if (mPulse) modelClear();
    else begin
      bit run, open, lw, cw, ex, np, nr;
      logic [31:0] nc;
      run  = mIntEn && !(mStall && dbgHalt);
      open = regWe && !mLocked;
      lw   = open && regAddr == 4'd0;
      cw   = open && regAddr == 4'd4 && regWdata[0];
      ex   = run && mCnt == 0 && !lw;
      np   = ex && mRaw && !cw && mRstEn;
      nr   = (mRaw && !cw) || ex;
      nc   = lw ? regWdata : ex ? mLoad : run ? mCnt - 1 : mCnt;
      if (lw) mLoad = regWdata;
      if (open && regAddr == 4'd2) begin
        mIntEn = mIntEn || regWdata[0];
        mRstEn = regWdata[1];
      end
      if (open && regAddr == 4'd6) mStall = regWdata[8];
      if (regWe && regAddr == 4'd5) mLocked = (regWdata != KEY);
      mCnt = nc; mRaw = nr; mPulse = np;
    end
  end

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      4'd0: return mLoad;
      4'd1: return mCnt;
      4'd2: return {30'd0, mRstEn, mIntEn};
      4'd3: return {31'd0, mRaw};
      4'd5: return {31'd0, mLocked};
      4'd6: return {23'd0, mStall, 8'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] a);
    case (a)
      4'd0: return "R8";
      4'd1: return "R4";
      4'd2: return "R9";
      4'd3: return "R5";
      4'd5: return "R2";
      4'd6: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R5", {31'd0, irqOut}, {31'd0, mRaw && mIntEn});
      check("R6", {31'd0, sysRstOut}, {31'd0, mPulse});
      check(tagOf(regAddr), regRdata, modelRead(regAddr));
      if (sysRstOut) sawPulse = 1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    regAddr = a; #0.5;
    check(tag, regRdata, exp);
  endtask

  task automatic readNow(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    regAddr = a; #0.5;
    v = regRdata;
  endtask

  task automatic waitHigh(input bit useIrq);
    int n = 0;
    while ((useIrq ? irqOut : sysRstOut) !== 1'b1 && n < 500) begin
      @(negedge clk); #1.5; n++;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    peek(4'd5, 32'd0, "R1");
    peek(4'd0, 32'hFFFF_FFFF, "R1");
    peek(4'd2, 32'd0, "R1");
    peek(4'd3, 32'd0, "R1");
    check("R1", {30'd0, irqOut, sysRstOut}, 32'd0);

    // R8 load takes effect at once
    wr(4'd0, 32'd20);
    peek(4'd1, 32'd20, "R8");

    // R4 counting, R5 first expiry
    wr(4'd2, 32'd3);
    readNow(4'd1, v1); readNow(4'd1, v2);
    check("R4", v2, v1 - 1);
    waitHigh(1);
    peek(4'd3, 32'd1, "R5");

    // R7 clear restores first-timeout state
    wr(4'd4, 32'd1);
    peek(4'd3, 32'd0, "R7");
    check("R7", {31'd0, irqOut}, 32'd0);
    waitHigh(1);
    check("R7", {31'd0, sysRstOut}, 32'd0);

    // R6 second expiry issues reset pulse
    waitHigh(0);
    check("R6", {31'd0, sysRstOut}, 32'd1);
    @(negedge clk); #1.5;
    check("R6", {31'd0, sysRstOut}, 32'd0);
    peek(4'd2, 32'd0, "R6");
    peek(4'd0, 32'hFFFF_FFFF, "R6");

    // R2 / R3 locking
    wr(4'd5, 32'hDEAD_DEAD);
    peek(4'd5, 32'd1, "R2");
    wr(4'd0, 32'd7);
    peek(4'd0, 32'hFFFF_FFFF, "R3");
    wr(4'd6, 32'h100);
    peek(4'd6, 32'd0, "R3");
    wr(4'd5, KEY);
    peek(4'd5, 32'd0, "R2");
    wr(4'd5, 32'd123);
    peek(4'd5, 32'd1, "R2");
    wr(4'd5, KEY);

    // R9 enable is sticky
    wr(4'd0, 32'd50);
    wr(4'd2, 32'd1);
    wr(4'd2, 32'd0);
    peek(4'd2, 32'd1, "R9");

    // R10 debug stall
    wr(4'd6, 32'h100);
    dbgHalt = 1'b1;
    readNow(4'd1, v1);
    repeat (5) @(negedge clk);
    readNow(4'd1, v2);
    check("R10", v2, v1);
    wr(4'd6, 32'd0);
    readNow(4'd1, v1);
    repeat (3) @(negedge clk);
    readNow(4'd1, v2);
    check("R10", {31'd0, v2 != v1}, 32'd1);
    dbgHalt = 1'b0;

    // R11 no reset when reset enable is clear
    sawPulse = 0;
    wr(4'd0, 32'd10);
    repeat (40) @(negedge clk);
    check("R11", {31'd0, sawPulse}, 32'd0);
    peek(4'd3, 32'd1, "R11");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule